// File: doc/BRIEF.md
# UART Software Flow Control Engine

This block adds in-band XON/XOFF flow control to a UART datapath. It sits between the character receiver, the receive FIFO and the transmit scheduler. Each received character is checked against programmed pause and resume codes. A recognized pause code stops the transmitter from taking new data at the next character boundary. A recognized resume code lets it continue. Characters that are not flow-control codes go on to the receive FIFO.

The block also watches the receive FIFO fill level. When the level climbs above a programmed halt threshold, it asks the transmitter to send the pause code or codes. When the level later drops to a programmed resume threshold, it asks for the resume code or codes. These control characters take priority over queued data and are cut to the configured word length.

Further modes are available. Codes can be single characters or two-character pairs. In the any-character-resumes mode, any received character ends a pause. In special-character mode, the block raises the interrupt on a match without pausing transmission.

Top module: `swfc_engine`

## Requirements
- R1: With the engine enabled and single-code mode selected, a received character equal to `xoff1` pauses the transmitter (`tx_halted`=1 after the next clock edge) and is not written to the receive FIFO.
- R2: While paused, `tx_fifo_pop` stays low even when `tx_ready` and `tx_fifo_valid` are both high. `tx_start` is only ever high together with `tx_ready`, so a character already being shifted out is never cut short.
- R3: In two-code mode, a pause needs `xoff1` followed directly by `xoff2`, and a resume needs `xon1` followed directly by `xon2`. A first code is held back and not written. A character that breaks a pair resets the matcher, and that character is then judged afresh.
- R4: A received `xon1` (single mode) or a received `xon1`,`xon2` pair (two-code mode) clears `tx_halted` and clears the pause interrupt status. Matched resume codes are not written to the FIFO.
- R5: Recognizing a pause raises `irq` only when `cfg_irq_en`=1. With `cfg_irq_en`=0, the transmitter still pauses and `irq` stays 0.
- R6: With `cfg_xon_any`=1 while paused, any received character resumes transmission. The resuming character is written to the FIFO unless it equals `xon1`, so a following `xon2` is written as data.
- R7: With `cfg_special`=1, a received character equal to `xoff2` raises `irq` (when enabled) without pausing. It is written to the FIFO, and the flag clears on a one-cycle `sts_rd` pulse.
- R8: When the engine is idle and `rx_level` > 4*`cfg_halt_thr`, the engine requests the pause code(s) (`xoff1`, then `xoff2` in two-code mode) on `tx_char`.
- R9: After a pause request has been made, when `rx_level` <= 4*`cfg_resume_thr`, the engine requests the resume code(s) (`xon1`, then `xon2` in two-code mode).
- R10: `cfg_wlen` selects 5, 6, 7 or 8 bits (codes 0..3). Control codes on `tx_char` keep only that many low bits, upper bits zero. Received characters are compared on those bits only.
- R11: A pending control character wins over FIFO data (`tx_fifo_pop`=0). It stays on `tx_char` until it is accepted by a cycle with `tx_ready`=1.
- R12: With `cfg_en`=0, every received character is written to the FIFO, `tx_halted` is 0, and no control character is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enable software flow control |
| cfg_two_code | input | 1 | 1 = two-character codes |
| cfg_xon_any | input | 1 | Any character resumes while paused |
| cfg_special | input | 1 | Special-character detect on `xoff2` |
| cfg_irq_en | input | 1 | Flow-control interrupt enable |
| cfg_wlen | input | 2 | Word length: 0=5, 1=6, 2=7, 3=8 bits |
| cfg_xon1 | input | 8 | First resume code |
| cfg_xon2 | input | 8 | Second resume code |
| cfg_xoff1 | input | 8 | First pause code |
| cfg_xoff2 | input | 8 | Second pause code / special character |
| cfg_halt_thr | input | 4 | Halt threshold, in units of 4 entries |
| cfg_resume_thr | input | 4 | Resume threshold, in units of 4 entries |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_level | input | 7 | Receive FIFO fill level |
| sts_rd | input | 1 | Interrupt status read strobe |
| tx_ready | input | 1 | Transmitter can accept a character |
| tx_fifo_valid | input | 1 | Transmit FIFO holds data |
| tx_fifo_data | input | 8 | Head of transmit FIFO |
| fifo_wr | output | 1 | Write strobe to receive FIFO |
| fifo_wdata | output | 8 | Character written to receive FIFO |
| tx_start | output | 1 | Transmitter takes `tx_char` this cycle |
| tx_char | output | 8 | Character offered to the transmitter |
| tx_fifo_pop | output | 1 | Pop the transmit FIFO |
| tx_halted | output | 1 | Transmission paused by remote |
| irq | output | 1 | Flow-control interrupt |

## Verification
Some properties are checked by assertions on every cycle. No data is popped while paused, and a start is never issued without `tx_ready`. A pending control request survives until it is accepted. Special matches never pause, and a disabled engine neither pauses nor requests codes. Other behaviour depends on particular character sequences and level histories, so only the bench scenarios show it. That covers the pair matching with its resets after broken sequences, the any-character resume, the order and truncation of the transmitted codes, and the interrupt set and clear rules.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int CW = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_OFF1 = 2'd1,
    SEQ_ON1  = 2'd2
  } seq_e;

  function automatic logic [CW-1:0] wlen_mask(input logic [1:0] wl);
    logic [CW-1:0] m;
    case (wl)
      2'd0:    m = 8'h1F;
      2'd1:    m = 8'h3F;
      2'd2:    m = 8'h7F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

  function automatic logic code_eq(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                   input logic [CW-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction
endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_two,
  input  logic          cfg_any,
  input  logic          cfg_spec,
  input  logic          cfg_irq_en,
  input  logic [CW-1:0] mask,
  input  logic [CW-1:0] xon1,
  input  logic [CW-1:0] xon2,
  input  logic [CW-1:0] xoff1,
  input  logic [CW-1:0] xoff2,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  input  logic          sts_rd,
  output logic          halted,
  output logic          fifo_wr,
  output logic [CW-1:0] fifo_wdata,
  output logic          irq
);
  seq_e          seq_q, seq_n;
  logic          halted_n, wr_n;
  logic          off_flag_q, off_flag_n, spc_flag_q, spc_flag_n;
  logic [CW-1:0] wdata_q;
  logic          m_on1, m_on2, m_off1, m_off2, hit_spc;
  logic          do_halt, do_resume;

  assign m_on1   = code_eq(rx_data, xon1, mask);
  assign m_on2   = code_eq(rx_data, xon2, mask);
  assign m_off1  = code_eq(rx_data, xoff1, mask);
  assign m_off2  = code_eq(rx_data, xoff2, mask);
  assign hit_spc = cfg_spec & m_off2;

  always_comb begin
    seq_n     = seq_q;
    wr_n      = 1'b0;
    do_halt   = 1'b0;
    do_resume = 1'b0;
    if (!cfg_en) begin
      seq_n = SEQ_IDLE;
      wr_n  = rx_valid;
    end else if (rx_valid) begin
      if (hit_spc) begin
        wr_n  = 1'b1;
        seq_n = SEQ_IDLE;
      end else if (halted && cfg_any) begin
        do_resume = 1'b1;
        wr_n      = ~m_on1;
        seq_n     = SEQ_IDLE;
      end else if (cfg_two) begin
        seq_n = SEQ_IDLE;
        if (seq_q == SEQ_OFF1 && m_off2)      do_halt = 1'b1;
        else if (seq_q == SEQ_ON1 && m_on2)   do_resume = 1'b1;
        else if (m_off1)                      seq_n = SEQ_OFF1;
        else if (m_on1)                       seq_n = SEQ_ON1;
        else                                  wr_n = 1'b1;
      end else begin
        seq_n = SEQ_IDLE;
        if (m_off1)     do_halt = 1'b1;
        else if (m_on1) do_resume = 1'b1;
        else            wr_n = 1'b1;
      end
    end
  end

  always_comb begin
    halted_n   = halted;
    off_flag_n = off_flag_q;
    spc_flag_n = spc_flag_q;
    if (!cfg_en) begin
      halted_n   = 1'b0;
      off_flag_n = 1'b0;
    end else if (do_halt) begin
      halted_n = 1'b1;
      if (cfg_irq_en) off_flag_n = 1'b1;
    end else if (do_resume) begin
      halted_n   = 1'b0;
      off_flag_n = 1'b0;
    end
    if (sts_rd) spc_flag_n = 1'b0;
    if (cfg_en && rx_valid && hit_spc && cfg_irq_en) spc_flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= SEQ_IDLE;
      halted     <= 1'b0;
      fifo_wr    <= 1'b0;
      wdata_q    <= '0;
      off_flag_q <= 1'b0;
      spc_flag_q <= 1'b0;
    end else begin
      seq_q      <= seq_n;
      halted     <= halted_n;
      fifo_wr    <= wr_n;
      off_flag_q <= off_flag_n;
      spc_flag_q <= spc_flag_n;
      if (wr_n) wdata_q <= rx_data;
    end
  end

  assign fifo_wdata = wdata_q;
  assign irq        = off_flag_q | spc_flag_q;

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(rx_valid && cfg_en)); // R1
  AST_WR_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(rx_valid)); // R12
  AST_DIS_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !halted); // R12
  AST_SPC_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && rx_valid && cfg_spec && code_eq(rx_data, xoff2, mask) && !halted) |=> !halted); // R7
endmodule

// File: rtl/swfc_tx_req.sv
module swfc_tx_req #(
  parameter int LVL_W     = 7,
  parameter int THR_W     = 4,
  parameter int THR_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_two,
  input  logic [THR_W-1:0] halt_thr,
  input  logic [THR_W-1:0] resume_thr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             ack,
  output logic             pend,
  output logic             is_on,
  output logic             second
);
  logic [LVL_W-1:0] halt_lvl, res_lvl;
  logic pend_n, is_on_n, second_n, sent_q, sent_n;

  assign halt_lvl = LVL_W'(halt_thr) << THR_SHIFT;
  assign res_lvl  = LVL_W'(resume_thr) << THR_SHIFT;

  always_comb begin
    pend_n   = pend;
    is_on_n  = is_on;
    second_n = second;
    sent_n   = sent_q;
    if (!cfg_en) begin
      pend_n   = 1'b0;
      second_n = 1'b0;
      sent_n   = 1'b0;
    end else if (pend) begin
      if (ack) begin
        if (cfg_two && !second) second_n = 1'b1;
        else begin
          pend_n   = 1'b0;
          second_n = 1'b0;
        end
      end
    end else if (!sent_q && rx_level > halt_lvl) begin
      pend_n  = 1'b1;
      is_on_n = 1'b0;
      sent_n  = 1'b1;
    end else if (sent_q && rx_level <= res_lvl) begin
      pend_n  = 1'b1;
      is_on_n = 1'b1;
      sent_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      is_on  <= 1'b0;
      second <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      pend   <= pend_n;
      is_on  <= is_on_n;
      second <= second_n;
      sent_q <= sent_n;
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack && cfg_en) |=> pend); // R11
  AST_NO_REQ_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !pend); // R12
endmodule

// File: rtl/swfc_tx_arb.sv
module swfc_tx_arb
  import swfc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend,
  input  logic [CW-1:0] ctrl_code,
  input  logic          halted,
  input  logic          tx_ready,
  input  logic          tx_fifo_valid,
  input  logic [CW-1:0] tx_fifo_data,
  output logic          tx_start,
  output logic [CW-1:0] tx_char,
  output logic          tx_fifo_pop,
  output logic          ack
);
  always_comb begin
    ack         = pend & tx_ready;
    tx_fifo_pop = tx_ready & ~pend & ~halted & tx_fifo_valid;
    tx_start    = ack | tx_fifo_pop;
    tx_char     = pend ? ctrl_code : tx_fifo_data;
  end

  AST_NO_POP_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_pop |-> !halted); // R2
  AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> tx_ready); // R2
endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
  import swfc_pkg::*;
#(
  parameter int LVL_W     = 7,
  parameter int THR_W     = 4,
  parameter int THR_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_two_code,
  input  logic             cfg_xon_any,
  input  logic             cfg_special,
  input  logic             cfg_irq_en,
  input  logic [1:0]       cfg_wlen,
  input  logic [7:0]       cfg_xon1,
  input  logic [7:0]       cfg_xon2,
  input  logic [7:0]       cfg_xoff1,
  input  logic [7:0]       cfg_xoff2,
  input  logic [THR_W-1:0] cfg_halt_thr,
  input  logic [THR_W-1:0] cfg_resume_thr,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             sts_rd,
  input  logic             tx_ready,
  input  logic             tx_fifo_valid,
  input  logic [7:0]       tx_fifo_data,
  output logic             fifo_wr,
  output logic [7:0]       fifo_wdata,
  output logic             tx_start,
  output logic [7:0]       tx_char,
  output logic             tx_fifo_pop,
  output logic             tx_halted,
  output logic             irq
);
  logic [CW-1:0] mask, ctrl_raw, ctrl_code;
  logic          pend, is_on, second, ack;

  assign mask      = wlen_mask(cfg_wlen);
  assign ctrl_raw  = is_on ? (second ? cfg_xon2 : cfg_xon1)
                           : (second ? cfg_xoff2 : cfg_xoff1);
  assign ctrl_code = ctrl_raw & mask;

  swfc_rx_match u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_two(cfg_two_code),
    .cfg_any(cfg_xon_any), .cfg_spec(cfg_special), .cfg_irq_en(cfg_irq_en),
    .mask(mask), .xon1(cfg_xon1), .xon2(cfg_xon2), .xoff1(cfg_xoff1),
    .xoff2(cfg_xoff2), .rx_valid(rx_valid), .rx_data(rx_data), .sts_rd(sts_rd),
    .halted(tx_halted), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .irq(irq)
  );

  swfc_tx_req #(.LVL_W(LVL_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT)) u_req (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_two(cfg_two_code),
    .halt_thr(cfg_halt_thr), .resume_thr(cfg_resume_thr), .rx_level(rx_level),
    .ack(ack), .pend(pend), .is_on(is_on), .second(second)
  );

  swfc_tx_arb u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .ctrl_code(ctrl_code),
    .halted(tx_halted), .tx_ready(tx_ready), .tx_fifo_valid(tx_fifo_valid),
    .tx_fifo_data(tx_fifo_data), .tx_start(tx_start), .tx_char(tx_char),
    .tx_fifo_pop(tx_fifo_pop), .ack(ack)
  );
endmodule

// File: tb/sim_swfc_engine.sv
module sim_swfc_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b1, cfg_two_code = 1'b0, cfg_xon_any = 1'b0, cfg_special = 1'b0;
  logic cfg_irq_en = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic [7:0] cfg_xon1 = 8'h11, cfg_xon2 = 8'h91, cfg_xoff1 = 8'h13, cfg_xoff2 = 8'h93;
  logic [3:0] cfg_halt_thr = 4'd15, cfg_resume_thr = 4'd0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [6:0] rx_level = 7'd0;
  logic sts_rd = 1'b0, tx_ready = 1'b0, tx_fifo_valid = 1'b1;
  logic [7:0] tx_fifo_data = 8'h5A;
  logic fifo_wr, tx_start, tx_fifo_pop, tx_halted, irq;
  logic [7:0] fifo_wdata, tx_char;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  swfc_engine u0 (.*);

  // {two_code, xon_any, char[7:0], expect_write, expect_halted}
  localparam logic [11:0] VEC [18] = '{
    {2'b00, 8'h41, 2'b10}, {2'b00, 8'h13, 2'b01}, {2'b00, 8'h41, 2'b11},
    {2'b00, 8'h11, 2'b00}, {2'b10, 8'h13, 2'b00}, {2'b10, 8'h93, 2'b01},
    {2'b10, 8'h11, 2'b01}, {2'b10, 8'h42, 2'b11}, {2'b10, 8'h11, 2'b01},
    {2'b10, 8'h91, 2'b00}, {2'b10, 8'h13, 2'b00}, {2'b10, 8'h41, 2'b10},
    {2'b10, 8'h93, 2'b10}, {2'b01, 8'h13, 2'b01}, {2'b01, 8'h55, 2'b10},
    {2'b01, 8'h13, 2'b01}, {2'b01, 8'h11, 2'b00}, {2'b01, 8'h91, 2'b10}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fifo_wr && !tx_halted && !irq && !tx_start, "reset", {fifo_wr, tx_halted, irq}, 0);

    // table walk: R1 R3 R6
    for (int i = 0; i < 18; i++) begin
      cfg_two_code = VEC[i][11];
      cfg_xon_any  = VEC[i][10];
      send(VEC[i][9:2]);
      chk(fifo_wr == VEC[i][1] && tx_halted == VEC[i][0] &&
          (!fifo_wr || fifo_wdata == VEC[i][9:2]),
          VEC[i][10] ? "R6 vec" : (VEC[i][11] ? "R3 vec" : "R1 vec"),
          {fifo_wr, tx_halted}, {VEC[i][1], VEC[i][0]});
    end

    // R5 / R2 / R4: interrupt enabled, transmit gating
    cfg_two_code = 1'b0; cfg_xon_any = 1'b0; cfg_irq_en = 1'b1;
    send(8'h13);
    chk(irq == 1'b1, "R5 irq set", irq, 1);
    tx_ready = 1'b1;
    #1;
    chk(!tx_fifo_pop && !tx_start, "R2 no pop while halted", {tx_fifo_pop, tx_start}, 0);
    send(8'h11);
    chk(!irq && !tx_halted && !fifo_wr, "R4 resume clears", {irq, tx_halted, fifo_wr}, 0);
    chk(tx_fifo_pop && tx_start && tx_char == 8'h5A, "R2 pop after resume", tx_char, 8'h5A);
    tx_ready = 1'b0;

    // R5 with enable off
    cfg_irq_en = 1'b0;
    send(8'h13);
    chk(tx_halted && !irq, "R5 masked", {tx_halted, irq}, 2);
    send(8'h11);

    // R7 special character
    cfg_irq_en = 1'b1; cfg_special = 1'b1;
    send(8'h93);
    chk(fifo_wr && fifo_wdata == 8'h93 && !tx_halted && irq, "R7 special",
        {fifo_wr, tx_halted, irq}, 5);
    @(negedge clk); sts_rd = 1'b1;
    @(negedge clk); sts_rd = 1'b0;
    chk(!irq, "R7 status read clears", irq, 0);
    cfg_special = 1'b0;

    // R10 masked receive compare (6 bits): 0x53 matches 0x13
    cfg_wlen = 2'd1;
    send(8'h53);
    chk(tx_halted && !fifo_wr, "R10 masked rx compare", tx_halted, 1);
    send(8'h11);

    // R8 R9 R10 R11 threshold-driven control characters, two-code, 6-bit
    cfg_two_code = 1'b1;
    cfg_xoff1 = 8'hD3; cfg_xoff2 = 8'hF4; cfg_xon1 = 8'h11; cfg_xon2 = 8'hA5;
    cfg_halt_thr = 4'd2; cfg_resume_thr = 4'd1;
    @(negedge clk); rx_level = 7'd8; tx_ready = 1'b1;
    @(negedge clk);
    chk(tx_char == 8'h5A && tx_fifo_pop, "R8 at threshold no request", tx_char, 8'h5A);
    rx_level = 7'd9; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_char == 8'h13 && !tx_start, "R11 held pending", tx_char, 8'h13);
    tx_ready = 1'b1;
    #1;
    chk(tx_start && !tx_fifo_pop && tx_char == 8'h13, "R8 xoff1 truncated first", tx_char, 8'h13);
    @(negedge clk);
    chk(tx_char == 8'h34 && !tx_fifo_pop, "R10 xoff2 truncated", tx_char, 8'h34);
    @(negedge clk);
    chk(tx_char == 8'h5A && tx_fifo_pop, "R11 data after codes", tx_char, 8'h5A);
    rx_level = 7'd5;
    repeat (2) @(negedge clk);
    chk(tx_char == 8'h5A, "R9 above resume no request", tx_char, 8'h5A);
    rx_level = 7'd4;
    @(negedge clk);
    chk(tx_char == 8'h11 && !tx_fifo_pop, "R9 xon1", tx_char, 8'h11);
    @(negedge clk);
    chk(tx_char == 8'h25, "R9 xon2 truncated", tx_char, 8'h25);
    @(negedge clk);
    chk(tx_char == 8'h5A && tx_fifo_pop, "R9 back to data", tx_char, 8'h5A);

    // R12 disabled
    cfg_en = 1'b0; cfg_wlen = 2'd3; cfg_two_code = 1'b0;
    cfg_xoff1 = 8'h13;
    send(8'h13);
    chk(fifo_wr && fifo_wdata == 8'h13 && !tx_halted, "R12 pass-through",
        {fifo_wr, tx_halted}, 2);
    rx_level = 7'd60;
    repeat (2) @(negedge clk);
    chk(tx_char == 8'h5A && tx_fifo_pop, "R12 no request", tx_char, 8'h5A);

    finish_run();
  end
endmodule